// File: doc/BRIEF.md
# Saturating Signed Arithmetic Unit

This block applies signed saturating arithmetic to two two's-complement operands. Each operation is requested by pulsing a valid strobe with an operation code. The supported operations are add, subtract, doubling of the second operand, and doubled forms of add and subtract that double the second operand before combining. A further add variant returns the wrapped sum and only reports the overflow.

Every result that goes out of range is clamped to the most positive or most negative representable value. A sticky flag records that clamping or an overflow has happened. Software-side logic clears the flag with an explicit clear strobe, and no arithmetic operation ever clears it. Results are registered and come out one cycle after the request.

Top module: `sat_alu`

## Requirements
- R1: Op code 0 (saturating add): when a and b have equal sign bits and the sign of a+b differs from a, the result is 0x80000000 if a is negative and 0x7FFFFFFF otherwise, and the flag is set. In all other cases the result is the plain sum.
- R2: Op code 1 (saturating subtract): when a and b differ in sign and the sign of a-b differs from a, the result is clamped toward the sign of a as in R1 and the flag is set. In all other cases the result is a-b.
- R3: Op code 2 (double) returns twice b, with a ignored. b at or above 0x40000000 gives 0x7FFFFFFF. b at or below 0xC0000000 (signed, equality included) gives 0x80000000. Either clamp sets the flag.
- R4: Op codes 3 and 4 (doubled add and doubled subtract) first double b as in R3. They then apply the saturating add (R1) or subtract (R2) to a and the doubled value. A clamp in either stage sets the flag.
- R5: Op code 5 (add with report) returns the wrapped sum a+b. It sets the flag on signed overflow as defined in R1.
- R6: The flag stays at 1 until flag_clr is sampled high on a cycle with no saturating event. If flag_clr and an event fall in the same cycle, the flag ends at 1.
- R7: out_valid is high exactly in the cycle after in_valid was sampled high. res changes only on cycles that follow an accepted request.
- R8: Op codes 6 and 7 produce a result of 0 and leave the flag unchanged.
- R9: After reset, res is 0, sat_flag is 0 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| a | input | 32 | First operand (signed) |
| b | input | 32 | Second operand (signed) |
| flag_clr | input | 1 | Synchronous clear of the sticky flag |
| res | output | 32 | Registered result |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bench targets the doubling thresholds exactly. It applies 0x40000000 and 0xC0000000, which must clamp, and 0xC0000001, which must not. A design using a strict comparison on the negative side would return 0x80000000 without raising the flag. In the doubled forms, one case clamps only in the doubling stage and the add stage then finishes in range. Another case clamps only in the add stage. A design that looks at one stage only would lose the flag in one of these two cases. Each vector is applied together with flag_clr, so a design that lets the clear override the event shows a cleared flag on every overflow vector. Separate directed cases show that a flag already set survives both non-saturating requests and reserved op codes.

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         flag_clr,
  output logic [W-1:0] res,
  output logic         out_valid,
  output logic         sat_flag
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_DBL = 3'd2,
                         OP_DADD = 3'd3, OP_DSUB = 3'd4, OP_ADDR = 3'd5;

  logic         dbl_hi, dbl_lo, dbl_sat, use_dbl;
  logic [W-1:0] dbl_val, opnd, sum, diff, clamp;
  logic         ovf_add, ovf_sub;
  logic [W-1:0] nxt_res;
  logic         evt;

  assign dbl_hi  = !b[W-1] && b[W-2];
  assign dbl_lo  = b[W-1] && (!b[W-2] || (b[W-3:0] == '0));
  assign dbl_sat = dbl_hi || dbl_lo;
  assign dbl_val = dbl_hi ? MAXV : dbl_lo ? MINV : {b[W-2:0], 1'b0};

  assign use_dbl = (op == OP_DADD) || (op == OP_DSUB);
  assign opnd    = use_dbl ? dbl_val : b;
  assign sum     = a + opnd;
  assign diff    = a - opnd;
  assign ovf_add = (a[W-1] == opnd[W-1]) && (sum[W-1] != a[W-1]);
  assign ovf_sub = (a[W-1] != opnd[W-1]) && (diff[W-1] != a[W-1]);
  assign clamp   = a[W-1] ? MINV : MAXV;

  always_comb begin
    nxt_res = '0;
    evt     = 1'b0;
    case (op)
      OP_ADD:  begin nxt_res = ovf_add ? clamp : sum;  evt = ovf_add; end
      OP_SUB:  begin nxt_res = ovf_sub ? clamp : diff; evt = ovf_sub; end
      OP_DBL:  begin nxt_res = dbl_val;                evt = dbl_sat; end
      OP_DADD: begin nxt_res = ovf_add ? clamp : sum;  evt = ovf_add || dbl_sat; end
      OP_DSUB: begin nxt_res = ovf_sub ? clamp : diff; evt = ovf_sub || dbl_sat; end
      OP_ADDR: begin nxt_res = sum;                    evt = ovf_add; end
      default: begin nxt_res = '0;                     evt = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res       <= '0;
      out_valid <= 1'b0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) res <= nxt_res;
      if (in_valid && evt) sat_flag <= 1'b1;
      else if (flag_clr)   sat_flag <= 1'b0;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R7
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(res)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (sat_flag && !flag_clr) |=> sat_flag); // R6
  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (flag_clr && !in_valid) |=> !sat_flag); // R6
  AST_POS_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ADD && !a[W-1] && !b[W-1]) |=> !res[W-1]); // R1
  AST_NEG_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SUB && a[W-1] && !b[W-1]) |=> res[W-1]); // R2
endmodule

// File: tb/test_sat_alu.sv
module test_sat_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        flag_clr = 1'b0;
  logic [31:0] res;
  logic        out_valid, sat_flag;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  sat_alu #(.W(32)) i_sat_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
    .flag_clr(flag_clr), .res(res), .out_valid(out_valid), .sat_flag(sat_flag)
  );

  localparam int NV = 19;
  // {op, a, b, expected result, expected flag}
  localparam logic [99:0] VEC [NV] = '{
    {3'd0, 32'h00000001, 32'h00000002, 32'h00000003, 1'b0},
    {3'd0, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1},
    {3'd0, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b1},
    {3'd0, 32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b0},
    {3'd1, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 1'b0},
    {3'd1, 32'h80000000, 32'h00000001, 32'h80000000, 1'b1},
    {3'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1},
    {3'd2, 32'h12345678, 32'h3FFFFFFF, 32'h7FFFFFFE, 1'b0},
    {3'd2, 32'h00000000, 32'h40000000, 32'h7FFFFFFF, 1'b1},
    {3'd2, 32'h00000000, 32'hC0000000, 32'h80000000, 1'b1},
    {3'd2, 32'h00000000, 32'hC0000001, 32'h80000002, 1'b0},
    {3'd3, 32'h00000010, 32'h00000008, 32'h00000020, 1'b0},
    {3'd3, 32'h00000000, 32'h40000000, 32'h7FFFFFFF, 1'b1},
    {3'd3, 32'h7FFFFFF0, 32'h00000010, 32'h7FFFFFFF, 1'b1},
    {3'd4, 32'h00000000, 32'hC0000001, 32'h7FFFFFFE, 1'b0},
    {3'd4, 32'hFFFFFFFF, 32'h40000000, 32'h80000000, 1'b1},
    {3'd5, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1},
    {3'd5, 32'h00000003, 32'h00000004, 32'h00000007, 1'b0},
    {3'd6, 32'h00000005, 32'h00000006, 32'h00000000, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] o, input logic [31:0] x,
                       input logic [31:0] y, input logic c);
    in_valid = v; op = o; a = x; b = y; flag_clr = c;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R9 res", res, 32'h0);
    check("R9 flag", {31'b0, sat_flag}, 32'h0);
    check("R9 valid", {31'b0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: clear raised with every vector, so the event must win (R6)
    for (int i = 0; i < NV; i++) begin
      logic [99:0] v;
      string tag;
      v = VEC[i];
      drive(1'b1, v[99:97], v[96:65], v[64:33], 1'b1);
      case (v[99:97])
        3'd0: tag = "R1"; 3'd1: tag = "R2"; 3'd2: tag = "R3";
        3'd3, 3'd4: tag = "R4"; 3'd5: tag = "R5"; default: tag = "R8";
      endcase
      check($sformatf("%s vec%0d res", tag, i), res, v[32:1]);
      check($sformatf("%s/R6 vec%0d flag", tag, i), {31'b0, sat_flag}, {31'b0, v[0]});
      check($sformatf("R7 vec%0d valid", i), {31'b0, out_valid}, 32'h1);
    end

    // R6: flag set, then non-saturating request without clear keeps it
    drive(1'b1, 3'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0);
    drive(1'b1, 3'd0, 32'h1, 32'h1, 1'b0);
    check("R6 sticky res", res, 32'h2);
    check("R6 sticky flag", {31'b0, sat_flag}, 32'h1);

    // R8: reserved op leaves set flag alone, result zero
    drive(1'b1, 3'd7, 32'h11, 32'h22, 1'b0);
    check("R8 res", res, 32'h0);
    check("R8 flag kept", {31'b0, sat_flag}, 32'h1);

    // R7: idle cycle holds result, no valid
    drive(1'b1, 3'd1, 32'h9, 32'h4, 1'b0);
    drive(1'b0, 3'd0, 32'h1234, 32'h1, 1'b0);
    check("R7 idle valid", {31'b0, out_valid}, 32'h0);
    check("R7 idle hold", res, 32'h5);
    check("R6 flag idle", {31'b0, sat_flag}, 32'h1);

    // R6: clear alone clears
    drive(1'b0, 3'd0, 32'h0, 32'h0, 1'b1);
    check("R6 clear", {31'b0, sat_flag}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule